// File: doc/BRIEF.md
# Bidirectional Port Controller with Peripheral Direction Override

This block drives a group of general-purpose pins from a small register bus. Software sets an output latch, a direction mask and a drive-strength mask. It reads back either a merged data view or the raw synchronised pin levels. Every pin has its own output-enable, output-value, reduced-drive and input lines toward the pad ring.

A routed serial-peripheral block can claim pin direction for a fixed subset of pins. The subset is chosen at elaboration by a mask parameter. While the peripheral enable is high, its per-pin direction lines replace the direction register on those pins. When the enable drops, the stored direction bits take effect again.

Pin inputs always pass through a synchroniser chain, even on pins that are driving. Reading the synchronised levels and comparing them with the driven value shows an overloaded or shorted output. The synchroniser makes pin samples reach the read path a fixed number of clocks late, which is two by default.

Top module: `pio_port8`

## Requirements
- R1: After reset, the output latch, the direction register and the drive register are all 0. pin_oe, pin_out and pin_weak are all 0.
- R2: Address 1 holds the direction register. A write there stores bus_wdata, a read returns the stored value, and both are allowed in any cycle. A direction bit of 1 makes its pin an output and 0 makes it an input.
- R3: Address 2 holds the drive register. A write stores bus_wdata and a read returns it. A bit of 1 requests reduced drive and 0 requests full drive.
- R4: A write to address 0 loads the output latch for all bits, input pins included. pin_out shows the new value from the next cycle on.
- R5: For a pin inside PERIPH_MASK (default bits 7..4), pin_oe follows per_dir while per_en is 1. In every other case pin_oe follows the direction register bit.
- R6: When per_en returns to 0, pin_oe again equals the direction register, without any rewrite.
- R7: A read of address 3 returns pin_in as it was exactly SYNC_STAGES clock edges earlier (2 by default). This holds for output pins as well as input pins.
- R8: A read of address 0 returns the output latch bit for each pin whose pin_oe is 1. For each pin whose pin_oe is 0, it returns the synchronised pin level.
- R9: pin_weak is the drive register bit ANDed with pin_oe, so reduced drive never shows on an input pin.
- R10: A write to address 3 has no effect. The output latch, the direction register, the drive register and the pin outputs all stay unchanged.
- R11: bus_rdata is combinational and reflects bus_addr in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 drive, 3 pin levels |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr |
| per_en | input | 1 | Peripheral enable, which claims direction of the masked pins |
| per_dir | input | WIDTH | Per-pin direction requested by the peripheral |
| pin_in | input | WIDTH | Raw pad input levels |
| pin_out | output | WIDTH | Output latch toward the pads |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_weak | output | WIDTH | Per-pin reduced-drive select |

## Verification
The checker looks at every cycle. It confirms that reduced drive never appears on a non-driving pin. It confirms that the masked pins follow the peripheral whenever it is enabled. It confirms that data and direction writes show up on the pins one cycle later. It confirms that the pin-level read equals the input from exactly two edges back, and that a write to the read-only address disturbs nothing.

Some behaviour only the bench scenarios can show. One is the merged data view, swept over combinations of direction, latch and pin values. Another is the return to stored direction after the peripheral lets go, with no rewrite. Others are the reset values and the exact cycle in which a pin change becomes visible.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned PIO_ADDR_W = 2;

   typedef enum logic [PIO_ADDR_W-1:0] {
      PIO_REG_OUT  = 2'd0,
      PIO_REG_DIR  = 2'd1,
      PIO_REG_DRV  = 2'd2,
      PIO_REG_PINS = 2'd3
   } pio_reg_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("pio_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[0] <= '0;
               else        stage[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/pio_dir_mux.sv
module pio_dir_mux #(
   parameter int unsigned      WIDTH       = 8,
   parameter logic [WIDTH-1:0] PERIPH_MASK = 'hF0
) (
   input  logic             per_en,
   input  logic [WIDTH-1:0] per_dir,
   input  logic [WIDTH-1:0] dir_reg,
   output logic [WIDTH-1:0] oe
);
   logic [WIDTH-1:0] unused_dir;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         if (PERIPH_MASK[i]) begin : g_shared
            assign oe[i]         = per_en ? per_dir[i] : dir_reg[i];
            assign unused_dir[i] = 1'b0;
         end else begin : g_port
            assign oe[i]         = dir_reg[i];
            assign unused_dir[i] = per_dir[i];
         end
      end
   endgenerate
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int unsigned      WIDTH   = 8,
   parameter logic [WIDTH-1:0] OUT_RST = '0,
   parameter logic [WIDTH-1:0] DIR_RST = '0,
   parameter logic [WIDTH-1:0] DRV_RST = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PIO_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic [WIDTH-1:0]      bus_wdata,
   output logic [WIDTH-1:0]      bus_rdata,
   input  logic [WIDTH-1:0]      oe,
   input  logic [WIDTH-1:0]      pins_sync,
   output logic [WIDTH-1:0]      out_q,
   output logic [WIDTH-1:0]      dir_q,
   output logic [WIDTH-1:0]      drv_q
);
   pio_reg_e sel;
   assign sel = pio_reg_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= OUT_RST;
         dir_q <= DIR_RST;
         drv_q <= DRV_RST;
      end else if (bus_wr) begin
         case (sel)
            PIO_REG_OUT: out_q <= bus_wdata;
            PIO_REG_DIR: dir_q <= bus_wdata;
            PIO_REG_DRV: drv_q <= bus_wdata;
            default:     ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         PIO_REG_OUT: bus_rdata = (out_q & oe) | (pins_sync & ~oe);
         PIO_REG_DIR: bus_rdata = dir_q;
         PIO_REG_DRV: bus_rdata = drv_q;
         default:     bus_rdata = pins_sync;
      endcase
   end
endmodule

// File: rtl/pio_port8.sv
module pio_port8
   import pio_pkg::*;
#(
   parameter int unsigned      WIDTH       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] PERIPH_MASK = 'hF0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PIO_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic [WIDTH-1:0]      bus_wdata,
   output logic [WIDTH-1:0]      bus_rdata,
   input  logic                  per_en,
   input  logic [WIDTH-1:0]      per_dir,
   input  logic [WIDTH-1:0]      pin_in,
   output logic [WIDTH-1:0]      pin_out,
   output logic [WIDTH-1:0]      pin_oe,
   output logic [WIDTH-1:0]      pin_weak
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("pio_port8: WIDTH must lie in 1..32");
      end
   endgenerate

   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] drv_q;

   pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_sync)
   );

   pio_dir_mux #(.WIDTH(WIDTH), .PERIPH_MASK(PERIPH_MASK)) i_mux (
      .per_en  (per_en),
      .per_dir (per_dir),
      .dir_reg (dir_q),
      .oe      (pin_oe)
   );

   pio_regs #(.WIDTH(WIDTH)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .oe        (pin_oe),
      .pins_sync (pins_sync),
      .out_q     (pin_out),
      .dir_q     (dir_q),
      .drv_q     (drv_q)
   );

   assign pin_weak = drv_q & pin_oe;
endmodule

// File: rtl/pio_port8_chk.sv
module pio_port8_chk #(
   parameter int unsigned      WIDTH       = 8,
   parameter logic [WIDTH-1:0] PERIPH_MASK = 'hF0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       bus_addr,
   input logic             bus_wr,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic             per_en,
   input logic [WIDTH-1:0] per_dir,
   input logic [WIDTH-1:0] pin_in,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_weak
);
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   AST_WEAK_ONLY_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_weak & ~pin_oe) == '0); // R9

   AST_PERIPH_OWNS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      per_en |-> ((pin_oe ^ per_dir) & PERIPH_MASK) == '0); // R5

   AST_DIR_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1) |=> ((pin_oe ^ $past(bus_wdata)) & ~PERIPH_MASK) == '0); // R2

   AST_OUT_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> pin_out == $past(bus_wdata)); // R4

   AST_PINS_LAG_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && bus_addr == 2'd3) |-> bus_rdata == $past(pin_in, 2)); // R7

   AST_PINS_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) |=> $stable(pin_out)); // R10
endmodule

bind pio_port8 pio_port8_chk #(.WIDTH(WIDTH), .PERIPH_MASK(PERIPH_MASK)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .per_en    (per_en),
   .per_dir   (per_dir),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .pin_weak  (pin_weak)
);

// File: tb/test_pio_port8.sv
module test_pio_port8;
   localparam int unsigned W    = 8;
   localparam logic [7:0]  MASK = 8'hF0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       per_en = 1'b0;
   logic [7:0] per_dir = '0;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out, pin_oe, pin_weak;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pio_port8 #(.WIDTH(W), .SYNC_STAGES(2), .PERIPH_MASK(MASK)) i_pio_port8 (
      .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
      .per_en, .per_dir, .pin_in, .pin_out, .pin_oe, .pin_weak
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   function automatic logic [7:0] rd(input logic [1:0] a);
      bus_addr = a;
      return bus_rdata;
   endfunction

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
   end

   initial begin
      logic [7:0] exp_oe;
      settle(2);
      rst_n = 1'b1;
      settle(1);
      // R1 reset state, R11 combinational reads
      bus_addr = 2'd1; #1 check("R1 dir", bus_rdata, 8'h00);
      bus_addr = 2'd2; #1 check("R1 drv", bus_rdata, 8'h00);
      bus_addr = 2'd0; #1 check("R1 data", bus_rdata, 8'h00);
      check("R1 oe", pin_oe, 8'h00);
      check("R1 out", pin_out, 8'h00);
      check("R1 weak", pin_weak, 8'h00);

      // R2 / R3 / R4 full value sweeps
      for (int v = 0; v < 256; v++) begin
         wr(2'd1, 8'(v));
         bus_addr = 2'd1; #1 check("R2 dir readback", bus_rdata, 8'(v));
         check("R2 oe follows dir", pin_oe, 8'(v));
         wr(2'd2, 8'(~v));
         bus_addr = 2'd2; #1 check("R3 drv readback", bus_rdata, 8'(~v));
         check("R9 weak", pin_weak, 8'(~v) & 8'(v));
         wr(2'd0, 8'(v ^ 8'h5A));
         check("R4 out latch", pin_out, 8'(v ^ 8'h5A));
      end

      // R4 latch loads on input pins, then appears on switching to output
      wr(2'd1, 8'h00);
      wr(2'd0, 8'hC3);
      check("R4 latch while input", pin_out, 8'hC3);
      wr(2'd1, 8'hFF);
      bus_addr = 2'd0; #1 check("R4 R8 data after switch", bus_rdata, 8'hC3);

      // R7 exact two-edge lag, on outputs and inputs
      for (int d = 0; d < 2; d++) begin
         wr(2'd1, d[0] ? 8'hFF : 8'h00);
         pin_in = 8'h00; settle(3);
         pin_in = 8'hA7;
         settle(1);
         bus_addr = 2'd3; #1 check("R7 after one edge", bus_rdata, 8'h00);
         settle(1);
         bus_addr = 2'd3; #1 check("R7 after two edges", bus_rdata, 8'hA7);
      end

      // R8 merged data view, per_en low
      for (int d = 0; d < 256; d += 17) begin
         for (int p = 0; p < 256; p += 51) begin
            wr(2'd1, 8'(d));
            wr(2'd0, 8'h3C);
            pin_in = 8'(p);
            settle(2);
            bus_addr = 2'd0; #1
            check("R8 merged read", bus_rdata, (8'h3C & 8'(d)) | (8'(p) & ~8'(d)));
         end
      end

      // R5 override sweep, R6 return without rewrite
      wr(2'd1, 8'h5A);
      wr(2'd2, 8'hFF);
      per_en = 1'b1;
      for (int v = 0; v < 256; v++) begin
         per_dir = 8'(v);
         #1 exp_oe = (8'(v) & MASK) | (8'h5A & ~MASK);
         check("R5 oe override", pin_oe, exp_oe);
         check("R9 weak override", pin_weak, exp_oe);
      end
      per_dir = 8'hA5; #1
      check("R5 oe fixed", pin_oe, 8'hAA);
      per_en = 1'b0; #1
      check("R6 oe restored", pin_oe, 8'h5A);
      bus_addr = 2'd1; #1 check("R6 dir kept", bus_rdata, 8'h5A);

      // R8 with peripheral-driven direction
      per_en = 1'b1; per_dir = 8'hF0;
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h99);
      pin_in = 8'h66; settle(2);
      bus_addr = 2'd0; #1 check("R8 merged with override", bus_rdata, 8'h96);
      per_en = 1'b0;

      // R10 write to pin-level address is inert
      wr(2'd1, 8'h33); wr(2'd2, 8'h11); wr(2'd0, 8'h77);
      wr(2'd3, 8'hFF);
      check("R10 out", pin_out, 8'h77);
      check("R10 oe", pin_oe, 8'h33);
      check("R10 weak", pin_weak, 8'h11);
      bus_addr = 2'd1; #1 check("R10 dir", bus_rdata, 8'h33);
      bus_addr = 2'd2; #1 check("R10 drv", bus_rdata, 8'h11);

      // R11 address change alone, no clock edge
      @(posedge clk); #2;
      bus_addr = 2'd2; #1 check("R11 same-cycle drv", bus_rdata, 8'h11);
      bus_addr = 2'd1; #1 check("R11 same-cycle dir", bus_rdata, 8'h33);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule